// File: doc/BRIEF.md
# Diamond Kernel Smoothing Filter (three streams)

This block smooths three raster streams of equal geometry in parallel with a fixed 5x5 low-pass kernel. The kernel's non-zero taps form a diamond around the centre pixel, and every weight is a power of two. Each weighted tap is therefore a left shift into a fixed-point accumulator, and a plain adder sums the taps. No multipliers are used. Each channel holds its vertical context in four line memories and a 5x5 register window. One shared scan controller tracks the frame position, so the three channels stay cycle-aligned.

Pixels arrive in raster order with a valid strobe, a start-of-frame marker on the first pixel and a start-of-line marker on the first pixel of each row. The block accepts one pixel per clock. An output pixel leaves two lines and three cycles after its own input pixel. After the last pixel of a frame the block advances by itself through the two missing lines, so the bottom rows are emitted without further input. The weights add up to 1/4, so each output is a quarter-scaled local average; callers that need unity gain apply the factor 4 downstream.

Top module: `diamond_smooth3`

## Requirements
- R1: After reset, `out_valid` stays low. A beat with `in_valid` high and `in_sof` low that arrives outside an open frame produces no output.
- R2: The output for a centre pixel is floor(S/128). S adds 16 times the centre, 2 times each of the four pixels one step up, down, left or right, and 1 times each of the four diagonal neighbours and the four pixels two steps straight up, down, left or right. The corners and knight-move positions of the 5x5 window contribute nothing. No output exceeds floor((2^DW-1)/4).
- R3: A tap whose row lies outside 0..IMG_H-1 or whose column lies outside 0..IMG_W-1 contributes zero, including at all four image corners.
- R4: Each frame produces exactly IMG_W*IMG_H output beats, in raster order (row 0 first, column 0 first in every row).
- R5: With an unbroken input stream, the first output of a frame is valid 2*IMG_W+4 clock edges after the edge that accepts the start-of-frame pixel, counting that edge as the first.
- R6: After the last pixel of a frame, the block emits the remaining outputs one per clock without further input. `in_valid` is ignored while this drain runs and after the frame until the next `in_sof`. The input must stay free of new frames until the drain completes, 2*IMG_W+3 cycles after the last pixel.
- R7: Channels A, B and C are filtered independently with the same kernel and leave on the same `out_valid` beat.
- R8: Cycles with `in_valid` low stall the filter without changing any output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a row |
| in_a | input | DW | Channel A pixel |
| in_b | input | DW | Channel B pixel |
| in_c | input | DW | Channel C pixel |
| out_valid | output | 1 | Filtered pixel present |
| out_a | output | DW | Channel A filtered |
| out_b | output | DW | Channel B filtered |
| out_c | output | DW | Channel C filtered |

## Verification
The self-driven drain that follows a frame and a beat offered on the input can meet in the same cycle. The bench provokes this by holding `in_valid` high with random data for the whole drain and some cycles after it. The collision is judged by the bottom two rows: they must still match the reference model computed from the stored frame, and the output count must remain exactly IMG_W*IMG_H. A second overlap, input bubbles arriving while outputs are being emitted, is exercised by a frame with regular gaps. Its values must equal those of an unbroken stream.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int K     = 5;   // window side
  localparam int TAPS  = K * K;
  localparam int FRAC  = 7;   // fractional bits kept in the accumulator

  // Right-shift amount of the weight at flat tap index t (row-major,
  // index 0 = newest row / newest column); -1 means weight zero.
  function automatic int tap_shift(input int t);
    int dr, dc, md;
    dr = 2 - (t / K);
    dc = 2 - (t % K);
    md = (dr < 0 ? -dr : dr) + (dc < 0 ? -dc : dc);
    case (md)
      0:       return 3;
      1:       return 6;
      2:       return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [TAPS-1:0] diamond_mask();
    logic [TAPS-1:0] m;
    for (int t = 0; t < TAPS; t++) m[t] = (tap_shift(t) >= 0);
    return m;
  endfunction

  // One tap scaled into FRAC fractional bits.
  function automatic logic [31:0] scaled_tap(input logic [31:0] x, input int t);
    if (tap_shift(t) < 0) return '0;
    return x << (FRAC - tap_shift(t));
  endfunction
endpackage

// File: rtl/dsf_scan_ctrl.sv
module dsf_scan_ctrl #(
  parameter int IMG_W = 12,
  parameter int IMG_H = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sof,
  input  logic                      in_sol,
  output logic                      adv,
  output logic                      draining,
  output logic                      win_fresh,
  output logic [dsf_pkg::TAPS-1:0]  tap_mask
);
  localparam int LAG = 2 * IMG_W + 2;
  localparam int CW  = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int RW  = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam int LW  = $clog2(LAG + 1);
  localparam logic [dsf_pkg::TAPS-1:0] DIAMOND = dsf_pkg::diamond_mask();

  logic          frame_open;
  logic [RW-1:0] in_r, nxt_r, em_r, crow;
  logic [CW-1:0] in_c, nxt_c, em_c, ccol;
  logic [LW-1:0] lag_cnt, drain_left;
  logic          in_take, sof_take, last_in, emit;

  assign in_take  = in_valid && !draining && (in_sof || frame_open);
  assign sof_take = in_take && in_sof;
  assign adv      = in_take || draining;

  always_comb begin
    nxt_r = in_r;
    nxt_c = in_c;
    if (in_sof) begin
      nxt_r = '0;
      nxt_c = '0;
    end else if (in_sol) begin
      nxt_r = in_r + RW'(1);
      nxt_c = '0;
    end else begin
      nxt_c = in_c + CW'(1);
    end
  end

  assign last_in = in_take && (nxt_r == RW'(IMG_H - 1)) && (nxt_c == CW'(IMG_W - 1));
  assign emit    = adv && !sof_take && (lag_cnt == LW'(LAG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_open <= 1'b0;
      draining   <= 1'b0;
      drain_left <= '0;
      lag_cnt    <= '0;
      in_r       <= '0;
      in_c       <= '0;
      em_r       <= '0;
      em_c       <= '0;
      crow       <= '0;
      ccol       <= '0;
      win_fresh  <= 1'b0;
    end else begin
      win_fresh <= emit;
      if (in_take) begin
        in_r <= nxt_r;
        in_c <= nxt_c;
      end
      if (sof_take) begin
        frame_open <= 1'b1;
        lag_cnt    <= LW'(1);
        em_r       <= '0;
        em_c       <= '0;
      end else if (adv && lag_cnt != LW'(LAG)) begin
        lag_cnt <= lag_cnt + LW'(1);
      end
      if (last_in) begin
        frame_open <= 1'b0;
        draining   <= 1'b1;
        drain_left <= LW'(LAG);
      end else if (draining) begin
        drain_left <= drain_left - LW'(1);
        if (drain_left == LW'(1)) draining <= 1'b0;
      end
      if (emit) begin
        crow <= em_r;
        ccol <= em_c;
        if (em_c == CW'(IMG_W - 1)) begin
          em_c <= '0;
          em_r <= em_r + RW'(1);
        end else begin
          em_c <= em_c + CW'(1);
        end
      end
    end
  end

  // Tap t sits at row crow+2-t/5 and column ccol+2-t%5.
  always_comb begin
    for (int t = 0; t < dsf_pkg::TAPS; t++) begin
      int r, c;
      r = int'(crow) + 2 - t / dsf_pkg::K;
      c = int'(ccol) + 2 - t % dsf_pkg::K;
      tap_mask[t] = (r >= 0) && (r < IMG_H) && (c >= 0) && (c < IMG_W);
    end
  end

  // R4
  centre_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_fresh |-> (int'(crow) < IMG_H) && (int'(ccol) < IMG_W));

  // R6
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(draining) |-> (crow == RW'(IMG_H - 1)) && (ccol == CW'(IMG_W - 1)));

  // R3
  corner_taps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_fresh && crow == '0 && ccol == '0) |-> $countones(tap_mask & DIAMOND) == 6);

  // R3
  centre_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_fresh |-> tap_mask[dsf_pkg::TAPS / 2]);
endmodule

// File: rtl/dsf_window.sv
module dsf_window #(
  parameter int DW    = 8,
  parameter int IMG_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  input  logic [DW-1:0]                pix,
  output logic [dsf_pkg::TAPS*DW-1:0]  win_flat
);
  localparam int K  = dsf_pkg::K;
  localparam int NL = K - 1;
  localparam int AW = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  logic [AW-1:0]         wp;
  logic [K-1:0][DW-1:0]  row_in;
  logic [DW-1:0]         win_q [K][K];

  assign row_in[0] = pix;

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_line
      logic [DW-1:0] mem [IMG_W];
      assign row_in[g+1] = mem[wp];
      always_ff @(posedge clk) begin
        if (adv) mem[wp] <= row_in[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      for (int i = 0; i < K; i++)
        for (int j = 0; j < K; j++) win_q[i][j] <= '0;
    end else if (adv) begin
      wp <= (wp == AW'(IMG_W - 1)) ? '0 : wp + AW'(1);
      for (int i = 0; i < K; i++) begin
        win_q[i][0] <= row_in[i];
        for (int j = 1; j < K; j++) win_q[i][j] <= win_q[i][j-1];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++) win_flat[(i*K+j)*DW +: DW] = win_q[i][j];
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(win_flat));
endmodule

// File: rtl/dsf_kernel.sv
module dsf_kernel #(
  parameter int DW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fresh,
  input  logic [dsf_pkg::TAPS*DW-1:0]  win_flat,
  input  logic [dsf_pkg::TAPS-1:0]     tap_mask,
  output logic                         out_valid,
  output logic [DW-1:0]                out_data
);
  localparam int SW = DW + 6;
  localparam logic [DW-1:0] QMAX = DW'(((64'd1 << DW) - 1) >> 2);

  logic [SW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int t = 0; t < dsf_pkg::TAPS; t++) begin
      if (tap_mask[t])
        acc = acc + SW'(dsf_pkg::scaled_tap(32'(win_flat[t*DW +: DW]), t));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fresh;
      if (fresh) out_data <= DW'(acc >> dsf_pkg::FRAC);
    end
  end

  // R2
  quarter_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data <= QMAX);
endmodule

// File: rtl/diamond_smooth3.sv
module diamond_smooth3 #(
  parameter int DW    = 8,
  parameter int IMG_W = 12,
  parameter int IMG_H = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_sol,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  output logic          out_valid,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic [DW-1:0] out_c
);
  localparam int NCH = 3;

  logic                        adv, draining, win_fresh;
  logic [dsf_pkg::TAPS-1:0]    tap_mask;
  logic [NCH-1:0][DW-1:0]      ch_in, ch_out;
  logic [NCH-1:0]              ch_valid;

  dsf_scan_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .adv(adv), .draining(draining), .win_fresh(win_fresh), .tap_mask(tap_mask)
  );

  assign ch_in[0] = draining ? '0 : in_a;
  assign ch_in[1] = draining ? '0 : in_b;
  assign ch_in[2] = draining ? '0 : in_c;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic [dsf_pkg::TAPS*DW-1:0] win_flat;
      dsf_window #(.DW(DW), .IMG_W(IMG_W)) win_i (
        .clk(clk), .rst_n(rst_n), .adv(adv), .pix(ch_in[g]), .win_flat(win_flat)
      );
      dsf_kernel #(.DW(DW)) ker_i (
        .clk(clk), .rst_n(rst_n), .fresh(win_fresh), .win_flat(win_flat),
        .tap_mask(tap_mask), .out_valid(ch_valid[g]), .out_data(ch_out[g])
      );
    end
  endgenerate

  assign out_valid = ch_valid[0];
  assign out_a     = ch_out[0];
  assign out_b     = ch_out[1];
  assign out_c     = ch_out[2];

  // R7
  lanes_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid[0] == ch_valid[1]) && (ch_valid[1] == ch_valid[2]));
endmodule

// File: tb/diamond_smooth3_tb_top.sv
`timescale 1ns/1ps
module diamond_smooth3_tb_top;
  localparam int DW  = 8;
  localparam int W   = 12;
  localparam int H   = 6;
  localparam int LAG = 2 * W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [DW-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic out_valid;
  logic [DW-1:0] out_a, out_b, out_c;

  always #2.5 clk = ~clk;

  diamond_smooth3 #(.DW(DW), .IMG_W(W), .IMG_H(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c)
  );

  int img [3][H][W];
  int n_cmp = 0, n_bad = 0;
  int out_idx = 0;
  int cyc = 0, sof_cyc = 0, first_cyc = -1;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int tap_w(input int dr, input int dc);
    int m;
    m = (dr < 0 ? -dr : dr) + (dc < 0 ? -dc : dc);
    if (m == 0) return 16;
    if (m == 1) return 2;
    if (m == 2) return 1;
    return 0;
  endfunction

  function automatic int model(input int ch, input int r, input int c);
    int s = 0;
    for (int dr = -2; dr <= 2; dr++)
      for (int dc = -2; dc <= 2; dc++)
        if (r + dr >= 0 && r + dr < H && c + dc >= 0 && c + dc < W)
          s += tap_w(dr, dc) * img[ch][r+dr][c+dc];
    return s / 128;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor: R2, R3, R4 (raster order), R7 per beat.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int r, c;
      if (out_idx == 0) first_cyc = cyc;
      if (out_idx >= W * H) begin
        chk("R4 extra beat", out_idx, W * H - 1);
      end else begin
        r = out_idx / W;
        c = out_idx % W;
        chk("R2/R3/R7 lane a", int'(out_a), model(0, r, c));
        chk("R2/R3/R7 lane b", int'(out_b), model(1, r, c));
        chk("R2/R3/R7 lane c", int'(out_c), model(2, r, c));
      end
      out_idx++;
    end
  end

  task automatic idle_inputs();
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
  endtask

  // gap: insert an idle cycle before every third pixel (R8)
  // junk: hold in_valid high with random data after the frame (R6)
  task automatic send_frame(input bit gap, input bit junk);
    out_idx = 0;
    first_cyc = -1;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        if (gap && ((r * W + c) % 3 == 1)) begin
          @(negedge clk);
          idle_inputs();
          in_a = DW'($urandom);
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sof = (r == 0 && c == 0);
        in_sol = (c == 0);
        in_a = DW'(img[0][r][c]);
        in_b = DW'(img[1][r][c]);
        in_c = DW'(img[2][r][c]);
        if (r == 0 && c == 0) sof_cyc = cyc;
      end
    end
    for (int k = 0; k < LAG + 8; k++) begin
      @(negedge clk);
      if (junk) begin
        in_valid = 1'b1; in_sof = 1'b0; in_sol = ($urandom % 2 == 0);
        in_a = DW'($urandom); in_b = DW'($urandom); in_c = DW'($urandom);
      end else begin
        idle_inputs();
      end
    end
    @(negedge clk);
    idle_inputs();
    repeat (4) @(negedge clk);
    chk("R4 beats per frame", out_idx, W * H);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", int'(out_valid), 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_sol = 1'b1; in_a = 8'hff;
    end
    @(negedge clk);
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R1 stray beats ignored", out_idx, 0);
  endtask

  task automatic test_random_latency();
    for (int ch = 0; ch < 3; ch++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) img[ch][r][c] = $urandom % 256;
    send_frame(1'b0, 1'b0);
    chk("R5 first output latency", first_cyc - sof_cyc, LAG + 2);
  endtask

  task automatic test_full_scale();
    for (int ch = 0; ch < 3; ch++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) img[ch][r][c] = 255;
    send_frame(1'b0, 1'b0);
  endtask

  task automatic test_impulse();
    for (int ch = 0; ch < 3; ch++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) img[ch][r][c] = 0;
    img[0][2][5] = 255;        // interior: diamond shape
    img[1][0][0] = 255;        // corner: R3 clipping
    img[2][H-1][W-1] = 255;    // bottom-right corner, emitted by drain
    send_frame(1'b0, 1'b0);
  endtask

  task automatic test_gaps();
    for (int ch = 0; ch < 3; ch++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) img[ch][r][c] = (ch * 37 + r * 29 + c * 11) % 256;
    send_frame(1'b1, 1'b0);
  endtask

  task automatic test_drain_junk();
    for (int ch = 0; ch < 3; ch++)
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++) img[ch][r][c] = (r == H - 1) ? 200 : $urandom % 64;
    send_frame(1'b0, 1'b1);
    chk("R6 no output after drain", int'(out_valid), 0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_random_latency();
    test_full_scale();
    test_impulse();
    test_gaps();
    test_drain_junk();
    test_random_latency();
    done = 1;
    report();
    $finish;
  end
endmodule